// File: doc/BRIEF.md
# Serial Firmware Upload Receiver

This block takes a firmware image from an external host over a byte stream while the rest of the device is held in reset. When both boot-select inputs are low after reset, it sends a prompt byte and waits for a frame. The frame is a marker byte, a 16-bit little-endian size, the binary, and a 16-bit CRC. The binary bytes go straight to an internal memory write port, starting at address 0. If the CRC matches, the block raises `done` for one cycle and stops.

Every wait is timed by counting a 1 ms tick input. There is a limit on the first byte, a limit on the gap between bytes, and a silence period after an error. A timeout, a bad marker, a size out of range or a CRC mismatch makes the block send a refusal byte. It then ignores the line until the host goes quiet or sends a clear-error byte, and after that it prompts again. Driving the select pin high during an upload halts the block until the next reset.

States and transitions:
- `S_IDLE` goes to `S_STX` when both enables are low.
- `S_STX` sends 02h and goes to `S_WAIT_HDR`.
- `S_WAIT_HDR` takes AAh and goes to `S_SZ_LO`.
- `S_SZ_LO` goes to `S_SZ_HI`.
- `S_SZ_HI` goes to `S_DATA` if the size is valid, or to `S_NAK` if it is not.
- `S_DATA` goes to `S_CRC_LO` after the last binary byte.
- `S_CRC_LO` goes to `S_CRC_HI`, and `S_CRC_HI` goes to `S_CHECK`.
- `S_CHECK` goes to `S_DONE` on a match or to `S_NAK` on a mismatch.
- `S_DONE` goes to `S_FINISHED`.
- `S_NAK` sends 15h and goes to `S_DRAIN`.
- `S_DRAIN` goes to `S_STX` after silence or on CEh.
- Any active state goes to `S_HALT` when `sel_n` is high.

Top module: `fwu_upload_rx`

## Requirements
- R1: After reset the block sends nothing, writes nothing and keeps `done` low. While `strap_n` is high it stays idle. Once `strap_n` and `sel_n` are both low it sends exactly one byte 02h on `tx_data` with `tx_valid`.
- R2: The first byte after a prompt must be AAh. Any other byte (except the case in R9) makes the block send 15h.
- R3: If 350 ticks of `tick_ms` arrive after the prompt with no byte received, the block sends 15h. A first byte that arrives after 349 ticks is accepted.
- R4: The size is sent low byte first. It counts the binary plus the two CRC bytes. If the size is above 7F00h or below 3, the block sends 15h right after the size high byte.
- R5: Each binary byte is written once on the memory port, unchanged, at addresses 0, 1, 2 and so on in the order received. No other byte is written.
- R6: After the marker, 20 ticks without a byte make the block send 15h. A gap of 19 ticks between bytes is accepted.
- R7: The CRC is computed MSB-first over the binary only, with polynomial 1021h and initial value FFFFh. It is received low byte first. On a match `done` pulses for exactly one cycle and nothing follows. On a mismatch the block sends 15h and `done` stays low.
- R8: After 15h, bytes are discarded, with no writes and no transmission. After 100 ticks without a byte the block sends 02h again. Any discarded byte other than CEh restarts the 100-tick count.
- R9: A CEh received after 15h makes the block send 02h at once. If a CEh is the first byte after a prompt while an error is still unacknowledged, it is ignored and the first-byte timer restarts.
- R10: If `sel_n` goes high once the block has left idle, it halts. It sends nothing more, writes nothing more and raises no `done` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_n | input | 1 | Boot strap, low to enable the upload mode |
| sel_n | input | 1 | Select pin, must stay low for the whole upload; high aborts |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte to transmit strobe |
| tx_data | output | 8 | Byte to transmit (02h or 15h) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle pulse on a good upload |

## Verification
The hardest case to reach from the ports is the recovery path after an error. Getting there needs an exact count of ticks, with the boundary one tick short and one tick long. Discarded bytes must also fall inside the silence window and restart it, which only a precise sequence of bytes and ticks can produce. The bench builds these sequences with directed tasks: a bad marker, a wrong size, a byte that comes late, a corrupted CRC, and CEh sent at each point where it matters. Between the directed cases it runs frames with random lengths, random gaps up to 19 ticks and random contents. For every frame it checks the memory image, the CRC and the bytes sent back.

// File: rtl/fwu_pkg.sv
package fwu_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STX,
        S_WAIT_HDR,
        S_SZ_LO,
        S_SZ_HI,
        S_DATA,
        S_CRC_LO,
        S_CRC_HI,
        S_CHECK,
        S_DONE,
        S_FINISHED,
        S_NAK,
        S_DRAIN,
        S_HALT
    } fwu_state_e;

    localparam logic [7:0] B_STX  = 8'h02;
    localparam logic [7:0] B_NAK  = 8'h15;
    localparam logic [7:0] B_MARK = 8'hAA;
    localparam logic [7:0] B_CLR  = 8'hCE;

    // one byte through a 16-bit CRC register, MSB first
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  din,
                                               input logic [15:0] poly);
        logic [15:0] c;
        c = crc_in ^ {din, 8'h00};
        for (int b = 0; b < 8; b++) begin
            c = c[15] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/fwu_tick_timer.sv
module fwu_tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/fwu_crc16.sv
module fwu_crc16
    import fwu_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    logic [15:0] crc_nxt;

    always_comb crc_nxt = crc16_byte(crc, din, POLY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= SEED;
        else if (init)
            crc <= SEED;
        else if (en)
            crc <= crc_nxt;
    end

endmodule

// File: rtl/fwu_upload_rx.sv
module fwu_upload_rx
    import fwu_pkg::*;
#(
    parameter int          ADDR_W     = 15,
    parameter int          CNT_W      = 16,
    parameter int          FIRST_MS   = 350,
    parameter int          GAP_MS     = 20,
    parameter int          SILENCE_MS = 100,
    parameter logic [15:0] MAX_SIZE   = 16'h7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_n,
    input  logic              sel_n,
    input  logic              tick_ms,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              done
);

    localparam logic [CNT_W-1:0] FIRST_LIM   = CNT_W'(FIRST_MS - 1);
    localparam logic [CNT_W-1:0] GAP_LIM     = CNT_W'(GAP_MS - 1);
    localparam logic [CNT_W-1:0] SILENCE_LIM = CNT_W'(SILENCE_MS - 1);
    localparam int MAX_A  = (FIRST_MS > GAP_MS) ? FIRST_MS : GAP_MS;
    localparam int MAX_MS = (MAX_A > SILENCE_MS) ? MAX_A : SILENCE_MS;
    localparam logic [15:0] MIN_SIZE = 16'd3;

    fwu_state_e        state, nxt;
    logic [15:0]       size_q;
    logic [ADDR_W-1:0] idx_q;
    logic [7:0]        crc_lo_q;
    logic [7:0]        crc_hi_q;
    logic              nak_pend;
    logic [CNT_W-1:0]  tmr_cnt;
    logic [CNT_W-1:0]  lim;
    logic              timed;
    logic              tmr_clr;
    logic              tmo;
    logic [15:0]       crc_calc;
    logic [15:0]       data_len;
    logic              last_data;
    logic [15:0]       size_full;
    logic              size_bad;
    logic              active;

    // ---------------- timeout selection ----------------
    always_comb begin
        lim   = GAP_LIM;
        timed = 1'b1;
        unique case (state)
            S_WAIT_HDR:                                  lim = FIRST_LIM;
            S_DRAIN:                                     lim = SILENCE_LIM;
            S_SZ_LO, S_SZ_HI, S_DATA, S_CRC_LO, S_CRC_HI: lim = GAP_LIM;
            default:                                     timed = 1'b0;
        endcase
    end

    assign tmr_clr = rx_valid || !timed;
    assign tmo     = tick_ms && !rx_valid && (tmr_cnt == lim);

    fwu_tick_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick_ms),
        .cnt   (tmr_cnt)
    );

    fwu_crc16 #(.POLY(16'h1021), .SEED(16'hFFFF)) i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (state == S_STX),
        .en    (state == S_DATA && rx_valid),
        .din   (rx_data),
        .crc   (crc_calc)
    );

    // ---------------- frame bookkeeping ----------------
    assign data_len  = size_q - 16'd2;
    assign last_data = (16'(idx_q) == data_len - 16'd1);
    assign size_full = {rx_data, size_q[7:0]};
    assign size_bad  = (size_full > MAX_SIZE) || (size_full < MIN_SIZE);
    assign active    = !(state == S_IDLE || state == S_FINISHED || state == S_HALT);

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        if (active && sel_n) begin
            nxt = S_HALT;
        end else begin
            unique case (state)
                S_IDLE:     if (!sel_n && !strap_n) nxt = S_STX;
                S_STX:      nxt = S_WAIT_HDR;
                S_WAIT_HDR: begin
                    if (rx_valid) begin
                        if (rx_data == B_MARK)
                            nxt = S_SZ_LO;
                        else if (!(rx_data == B_CLR && nak_pend))
                            nxt = S_NAK;
                    end else if (tmo) begin
                        nxt = S_NAK;
                    end
                end
                S_SZ_LO:    if (rx_valid) nxt = S_SZ_HI;
                            else if (tmo) nxt = S_NAK;
                S_SZ_HI:    if (rx_valid) nxt = size_bad ? S_NAK : S_DATA;
                            else if (tmo) nxt = S_NAK;
                S_DATA:     if (rx_valid && last_data) nxt = S_CRC_LO;
                            else if (!rx_valid && tmo) nxt = S_NAK;
                S_CRC_LO:   if (rx_valid) nxt = S_CRC_HI;
                            else if (tmo) nxt = S_NAK;
                S_CRC_HI:   if (rx_valid) nxt = S_CHECK;
                            else if (tmo) nxt = S_NAK;
                S_CHECK:    nxt = (crc_calc == {crc_hi_q, crc_lo_q}) ? S_DONE : S_NAK;
                S_DONE:     nxt = S_FINISHED;
                S_NAK:      nxt = S_DRAIN;
                S_DRAIN:    if (rx_valid && rx_data == B_CLR) nxt = S_STX;
                            else if (tmo) nxt = S_STX;
                S_FINISHED: nxt = S_FINISHED;
                S_HALT:     nxt = S_HALT;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // ---------------- state register and frame registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            size_q   <= '0;
            idx_q    <= '0;
            crc_lo_q <= '0;
            crc_hi_q <= '0;
            nak_pend <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_SZ_LO && rx_valid)
                size_q[7:0] <= rx_data;
            if (state == S_SZ_HI && rx_valid) begin
                size_q[15:8] <= rx_data;
                idx_q        <= '0;
            end
            if (state == S_DATA && rx_valid)
                idx_q <= idx_q + 1'b1;
            if (state == S_CRC_LO && rx_valid)
                crc_lo_q <= rx_data;
            if (state == S_CRC_HI && rx_valid)
                crc_hi_q <= rx_data;
            if (state == S_NAK)
                nak_pend <= 1'b1;
            else if (state == S_WAIT_HDR && rx_valid)
                nak_pend <= 1'b0;
            else if (state == S_DRAIN && rx_valid && rx_data == B_CLR)
                nak_pend <= 1'b0;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        done      = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = idx_q;
        mem_wdata = rx_data;
        unique case (state)
            S_STX:   begin tx_valid = 1'b1; tx_data = B_STX; end
            S_NAK:   begin tx_valid = 1'b1; tx_data = B_NAK; end
            S_DONE:  done = 1'b1;
            S_DATA:  mem_we = rx_valid && !sel_n;
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    // R1
    tx_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data == B_STX || tx_data == B_NAK));

    // R5
    mem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (16'(mem_addr) < size_q - 16'd2));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !tx_valid && !mem_we));

    // R8
    nak_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_data == B_NAK) |=> (!tx_valid && !mem_we && !done));

    // R6
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tmr_cnt) <= MAX_MS));

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && active) |=> (!tx_valid && !mem_we && !done));

endmodule

// File: tb/test_fwu_upload_rx.sv
`timescale 1ns/1ps
module test_fwu_upload_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_n = 1'b1;
    logic       sel_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       mem_we;
    logic [14:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0] tx_log [0:255];
    int         tx_cnt = 0;
    logic [7:0] bmem [0:127];
    int         wr_cnt = 0;
    int         bad_addr = 0;
    int         done_cnt = 0;
    logic [7:0] payload [0:127];

    always #4 clk = ~clk;   // 125 MHz

    fwu_upload_rx i_fwu_upload_rx (
        .clk(clk), .rst_n(rst_n), .strap_n(strap_n), .sel_n(sel_n),
        .tick_ms(tick_ms), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
    );

    // monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid === 1'b1) begin
                if (tx_cnt < 256) tx_log[tx_cnt] = tx_data;
                tx_cnt++;
            end
            if (mem_we === 1'b1) begin
                if (mem_addr < 15'd128) bmem[mem_addr[6:0]] = mem_wdata;
                else bad_addr++;
                wr_cnt++;
            end
            if (done === 1'b1) done_cnt++;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {payload[i], 8'h00};
            for (int b = 0; b < 8; b++)
                c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send(logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 tick_ms = 1'b1;
            @(posedge clk); #1 tick_ms = 1'b0;
        end
    endtask

    function automatic logic [7:0] last_tx();
        return (tx_cnt > 0) ? tx_log[tx_cnt-1] : 8'hXX;
    endfunction

    // reset, then enable the mode
    task automatic restart();
        rst_n = 1'b0; strap_n = 1'b1; sel_n = 1'b0;
        rx_valid = 1'b0; tick_ms = 1'b0;
        cyc(3);
        tx_cnt = 0; wr_cnt = 0; done_cnt = 0; bad_addr = 0;
        rst_n = 1'b1;
        cyc(3);
        strap_n = 1'b0;
        cyc(4);
    endtask

    task automatic fill(int n);
        for (int i = 0; i < n; i++) payload[i] = 8'($urandom);
    endtask

    // header + payload (+crc); gap ticks before every byte after the marker
    task automatic send_frame(int n, int gap, bit bad_crc);
        logic [15:0] sz = 16'(n + 2);
        logic [15:0] c  = ref_crc(n);
        if (bad_crc) c = c ^ 16'h0100;
        send(8'hAA);
        ticks(gap); send(sz[7:0]);
        ticks(gap); send(sz[15:8]);
        for (int i = 0; i < n; i++) begin
            ticks(gap); send(payload[i]);
        end
        ticks(gap); send(c[7:0]);
        ticks(gap); send(c[15:8]);
        cyc(4);
    endtask

    task automatic check_image(int n, string tag);
        int mism = 0;
        for (int i = 0; i < n; i++) if (bmem[i] !== payload[i]) mism++;
        check(wr_cnt == n, {tag, " write count"}, wr_cnt, n);
        check(mism == 0 && bad_addr == 0, {tag, " memory image"}, mism, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // ---- R1: reset state, strap high keeps idle ----
        rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(2);
        check(tx_valid == 1'b0 && mem_we == 1'b0 && done == 1'b0, "R1 reset outputs",
              {tx_valid, mem_we, done}, 0);
        cyc(20);
        check(tx_cnt == 0, "R1 idle while strap high", tx_cnt, 0);
        strap_n = 1'b0; cyc(6);
        check(tx_cnt == 1 && last_tx() == 8'h02, "R1 single STX", last_tx(), 8'h02);

        // ---- R5 R7: good frame ----
        fill(17);
        send_frame(17, 0, 1'b0);
        check_image(17, "R5 good frame");
        check(done_cnt == 1, "R7 done pulse", done_cnt, 1);
        cyc(30);
        check(done_cnt == 1 && tx_cnt == 1, "R7 nothing after done", tx_cnt, 1);

        // ---- R2: wrong marker; R8: drain and silence restart ----
        restart();
        send(8'h55); cyc(3);
        check(last_tx() == 8'h15, "R2 bad marker NAK", last_tx(), 8'h15);
        ticks(99);
        send(8'h11); send(8'hAA); cyc(2);
        check(tx_cnt == 2 && wr_cnt == 0, "R8 discard inside silence", tx_cnt, 2);
        ticks(99); cyc(3);
        check(tx_cnt == 2, "R8 no restart after 99 ticks", tx_cnt, 2);
        ticks(1); cyc(3);
        check(tx_cnt == 3 && last_tx() == 8'h02, "R8 STX after silence", last_tx(), 8'h02);
        // R9: CE as first byte with error pending is ignored
        send(8'hCE); cyc(3);
        check(tx_cnt == 3, "R9 CE ignored after prompt", tx_cnt, 3);
        fill(5); send_frame(5, 0, 1'b0);
        check(done_cnt == 1, "R9 session after CE", done_cnt, 1);
        check_image(5, "R9");

        // ---- R3: first-byte limit ----
        restart();
        ticks(349);
        fill(4); send_frame(4, 0, 1'b0);
        check(done_cnt == 1 && tx_cnt == 1, "R3 349 ticks accepted", done_cnt, 1);
        restart();
        ticks(350); cyc(3);
        check(tx_cnt == 2 && last_tx() == 8'h15, "R3 350 ticks NAK", last_tx(), 8'h15);
        // R9: CE after NAK prompts immediately
        send(8'hCE); cyc(3);
        check(tx_cnt == 3 && last_tx() == 8'h02, "R9 CE restarts", last_tx(), 8'h02);

        // ---- R4: size limits ----
        restart();
        send(8'hAA); send(8'h01); send(8'h7F); cyc(3);
        check(last_tx() == 8'h15 && wr_cnt == 0, "R4 size 7F01 NAK", last_tx(), 8'h15);
        restart();
        send(8'hAA); send(8'h02); send(8'h00); cyc(3);
        check(last_tx() == 8'h15, "R4 size 2 NAK", last_tx(), 8'h15);
        restart();
        send(8'hAA); send(8'h00); send(8'h7F); send(8'h33); cyc(3);
        check(tx_cnt == 1 && wr_cnt == 1, "R4 size 7F00 accepted", tx_cnt, 1);

        // ---- R6: inter-byte gap ----
        restart();
        fill(6); send_frame(6, 19, 1'b0);
        check(done_cnt == 1 && tx_cnt == 1, "R6 gap 19 accepted", done_cnt, 1);
        check_image(6, "R6");
        restart();
        send(8'hAA); send(8'h08); ticks(20); cyc(3);
        check(tx_cnt == 2 && last_tx() == 8'h15, "R6 gap 20 NAK", last_tx(), 8'h15);

        // ---- R7: CRC mismatch ----
        restart();
        fill(9); send_frame(9, 0, 1'b1);
        check(done_cnt == 0 && last_tx() == 8'h15, "R7 bad CRC NAK", last_tx(), 8'h15);

        // ---- R10: abort ----
        restart();
        send(8'hAA); send(8'h0C); send(8'h00); send(8'h01); send(8'h02);
        sel_n = 1'b1; cyc(2);
        sel_n = 1'b0;
        for (int i = 0; i < 12; i++) send(8'(i));
        ticks(400); cyc(3);
        check(wr_cnt == 2 && tx_cnt == 1 && done_cnt == 0, "R10 halted", wr_cnt, 2);

        // ---- random frames: R5 R7 R6 ----
        for (int k = 0; k < 8; k++) begin
            int n = 1 + int'($urandom % 64);
            int g = int'($urandom % 20);
            restart();
            fill(n);
            send_frame(n, g, 1'b0);
            check(done_cnt == 1 && tx_cnt == 1, "R7 random frame done", done_cnt, 1);
            check_image(n, "R5 random frame");
        end

        summary();
    end

endmodule